// File: doc/BRIEF.md
# Pixel Bus Unpacking Multiplexer

This block sits between a wide pixel bus and a colour lookup stage. A bus word is taken in whole, on a one-cycle load strobe that stands for the rising edge of the slow shift clock. The block then sends out one pixel per pixel-clock cycle. The mode setting decides how the word is split into groups and in which order the groups leave. The lowest-numbered group always goes first.

Pixel modes deliver an 8-bit palette address on `pix_data`; 4-bit pixels are widened with zeros. In true-colour mode the three colour bytes come out on their own outputs and the overlay byte comes out on `pix_data`. The number of pixels sent per load comes from a separate divide-ratio input, not from the mode. When the divide ratio does not match the pixel count the mode naturally needs, a sticky flag is raised and the block still runs for the programmed count.

Top module: `pixbus_unpack`

## Requirements
- R1: `mode_ctl[5:0]` selects 8-bit pixels. Code 0 is an 8-bit bus with one group (bits 7:0). Code 1 is a 16-bit bus with groups 7:0 then 15:8. Code 2 is a 32-bit bus with groups 7:0, 15:8, 23:16, 31:24, sent in that order. Codes above 5 behave as code 0.
- R2: Code 3 takes four 4-bit pixels from a 16-bit bus in the order 3:0, 7:4, 11:8, 15:12. Each pixel is zero-extended to 8 bits on `pix_data`.
- R3: Code 4 is the nibble mode on a 32-bit bus, and `nib_sel` is captured at load. With `nib_sel`=0 the pixels are bits 3:0, 11:8, 19:16, 27:24. With `nib_sel`=1 they are bits 7:4, 15:12, 23:20, 31:28. Each pixel is zero-extended.
- R4: Code 5 is true colour with one group. `blue` = bits 31:24, `green` = bits 23:16, `red` = bits 15:8, and the overlay (bits 7:0) appears on `pix_data`. In all other modes, and whenever `pix_valid` is low, `red`, `green` and `blue` are zero.
- R5: When `ovl_en` is 0 at load, the true-colour overlay on `pix_data` is forced to zero.
- R6: After a load, `pix_valid` is high for exactly N consecutive cycles, starting the cycle after the load, with one pixel per cycle. N is `div_ratio`, with 0 treated as 1. `pix_data` is zero while `pix_valid` is low.
- R7: If N differs from the mode's natural count (1 for codes 0 and 5, 2 for code 1, 4 otherwise), the group used for pixel k is k modulo the natural count. Extra cycles reuse groups and a short count drops the later groups.
- R8: `ratio_err` goes high the cycle after a load whose N differs from the natural count, and stays high until reset.
- R9: A load during an unfinished sequence replaces the word and restarts the output at group 0 the next cycle.
- R10: `mode_ctl[7:6]` have no effect.
- R11: Synchronous active-high `rst` clears `pix_valid` and `ratio_err` by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-cycle strobe: capture bus word (shift-clock edge) |
| bus_word | input | 32 | Pixel bus word |
| mode_ctl | input | 8 | Mode control; bits 5:0 used |
| div_ratio | input | 3 | Pixels emitted per load |
| nib_sel | input | 1 | Nibble-mode half select |
| ovl_en | input | 1 | Overlay enable in true-colour mode |
| pix_valid | output | 1 | One pixel presented this cycle |
| pix_data | output | 8 | Palette address or overlay byte |
| red | output | 8 | True-colour red byte |
| green | output | 8 | True-colour green byte |
| blue | output | 8 | True-colour blue byte |
| ratio_err | output | 1 | Sticky divide-ratio mismatch flag |

## Verification
The bench builds the block with its package defaults: a 32-bit bus, 8-bit pixels and a 3-bit pixel counter. With those values every mode code can be reached, as can divide ratios from 0 to 7, including ratios below, equal to and above every natural count. A reference model queues the expected pixel stream for each load and compares it cycle by cycle. The stimulus covers back-to-back loads, restarts in the middle of a sequence, set upper mode bits, and a reset issued during a mismatched sequence.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    localparam int BUS_W  = 32;
    localparam int PIX_W  = 8;
    localparam int NIB_W  = 4;
    localparam int LANES  = BUS_W / PIX_W;
    localparam int SEL_W  = $clog2(LANES);
    localparam int CNT_W  = 3;
    localparam int CODE_W = 6;
    localparam int CTL_W  = 8;

    typedef enum logic [2:0] {
        PM_B8  = 3'd0,
        PM_B16 = 3'd1,
        PM_B32 = 3'd2,
        PM_N16 = 3'd3,
        PM_NIB = 3'd4,
        PM_TC  = 3'd5
    } pmode_e;

    typedef struct packed {
        logic [BUS_W-1:0] word;
        pmode_e           mode;
        logic             nib_hi;
        logic             ovl_en;
        logic [CNT_W-1:0] ratio;
    } load_s;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] red;
        logic [PIX_W-1:0] green;
        logic [PIX_W-1:0] blue;
    } pixel_s;

    function automatic pmode_e decode_mode(input logic [CODE_W-1:0] code);
        case (code)
            6'd1:    return PM_B16;
            6'd2:    return PM_B32;
            6'd3:    return PM_N16;
            6'd4:    return PM_NIB;
            6'd5:    return PM_TC;
            default: return PM_B8;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] natural_cnt(input pmode_e m);
        case (m)
            PM_B8, PM_TC: return CNT_W'(1);
            PM_B16:       return CNT_W'(2);
            default:      return CNT_W'(LANES);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] eff_ratio(input logic [CNT_W-1:0] r);
        return (r == '0) ? CNT_W'(1) : r;
    endfunction

endpackage

// File: rtl/pbm_load_reg.sv
module pbm_load_reg
    import pbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  load_s            nxt,
    output load_s            cur,
    output logic             active,
    output logic [CNT_W-1:0] idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            active <= 1'b0;
            idx    <= '0;
        end else if (load) begin
            cur    <= nxt;
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (idx == cur.ratio - CNT_W'(1)) begin
                active <= 1'b0;
            end else begin
                idx <= idx + CNT_W'(1);
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        active |-> (idx < cur.ratio)); // R6

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        load |=> (active && idx == '0)); // R9

endmodule

// File: rtl/pbm_group_sel.sv
module pbm_group_sel
    import pbm_pkg::*;
(
    input  load_s            cur,
    input  logic [CNT_W-1:0] idx,
    output pixel_s           px
);

    logic [PIX_W-1:0] lane_byte [LANES];
    logic [NIB_W-1:0] lane_lo   [LANES];
    logic [NIB_W-1:0] lane_hi   [LANES];
    logic [NIB_W-1:0] nib16     [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_byte[i] = cur.word[i*PIX_W +: PIX_W];
        assign lane_lo[i]   = cur.word[i*PIX_W +: NIB_W];
        assign lane_hi[i]   = cur.word[i*PIX_W + NIB_W +: NIB_W];
        assign nib16[i]     = cur.word[i*NIB_W +: NIB_W];
    end

    logic [CNT_W-1:0] gidx;
    logic [SEL_W-1:0] grp;
    logic             unused_gidx_msb;

    assign gidx            = idx & (natural_cnt(cur.mode) - CNT_W'(1));
    assign grp             = gidx[SEL_W-1:0];
    assign unused_gidx_msb = gidx[CNT_W-1];

    always_comb begin
        px = '0;
        case (cur.mode)
            PM_B8:  px.pix = lane_byte[0];
            PM_B16,
            PM_B32: px.pix = lane_byte[grp];
            PM_N16: px.pix = {{(PIX_W-NIB_W){1'b0}}, nib16[grp]};
            PM_NIB: px.pix = {{(PIX_W-NIB_W){1'b0}},
                              cur.nib_hi ? lane_hi[grp] : lane_lo[grp]};
            PM_TC: begin
                px.pix   = cur.ovl_en ? lane_byte[0] : '0;
                px.red   = lane_byte[1];
                px.green = lane_byte[2];
                px.blue  = lane_byte[3];
            end
            default: px = '0;
        endcase
    end

endmodule

// File: rtl/pbm_ratio_chk.sv
module pbm_ratio_chk
    import pbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  pmode_e           mode,
    input  logic [CNT_W-1:0] ratio,
    output logic             err
);

    logic mismatch;
    assign mismatch = (ratio != natural_cnt(mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (load && mismatch) begin
            err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R8

    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        (load && mismatch) |=> err); // R8

endmodule

// File: rtl/pixbus_unpack.sv
module pixbus_unpack
    import pbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BUS_W-1:0] bus_word,
    input  logic [CTL_W-1:0] mode_ctl,
    input  logic [CNT_W-1:0] div_ratio,
    input  logic             nib_sel,
    input  logic             ovl_en,
    output logic             pix_valid,
    output logic [PIX_W-1:0] pix_data,
    output logic [PIX_W-1:0] red,
    output logic [PIX_W-1:0] green,
    output logic [PIX_W-1:0] blue,
    output logic             ratio_err
);

    load_s            nxt;
    load_s            cur;
    logic             active;
    logic [CNT_W-1:0] idx;
    pixel_s           px;
    logic             unused_mode_hi;

    assign unused_mode_hi = ^mode_ctl[CTL_W-1:CODE_W];

    always_comb begin
        nxt.word   = bus_word;
        nxt.mode   = decode_mode(mode_ctl[CODE_W-1:0]);
        nxt.nib_hi = nib_sel;
        nxt.ovl_en = ovl_en;
        nxt.ratio  = eff_ratio(div_ratio);
    end

    pbm_load_reg u_load (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .nxt    (nxt),
        .cur    (cur),
        .active (active),
        .idx    (idx)
    );

    pbm_group_sel u_sel (
        .cur (cur),
        .idx (idx),
        .px  (px)
    );

    pbm_ratio_chk u_chk (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .mode  (nxt.mode),
        .ratio (nxt.ratio),
        .err   (ratio_err)
    );

    assign pix_valid = active;
    assign pix_data  = active ? px.pix   : '0;
    assign red       = active ? px.red   : '0;
    assign green     = active ? px.green : '0;
    assign blue      = active ? px.blue  : '0;

    AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> pix_valid); // R6

    AST_NIB_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && (cur.mode == PM_N16 || cur.mode == PM_NIB))
            |-> (pix_data[PIX_W-1:NIB_W] == '0)); // R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!pix_valid && !ratio_err)); // R11

    AST_RGB_ONLY_TC: assert property (@(posedge clk) disable iff (rst)
        (cur.mode != PM_TC) |-> ({red, green, blue} == '0)); // R4

endmodule

// File: tb/tb_pixbus_unpack.sv
module tb_pixbus_unpack;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        load;
    logic [31:0] bus_word;
    logic [7:0]  mode_ctl;
    logic [2:0]  div_ratio;
    logic        nib_sel;
    logic        ovl_en;
    logic        pix_valid;
    logic [7:0]  pix_data, red, green, blue;
    logic        ratio_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixbus_unpack dut (
        .clk(clk), .rst(rst), .load(load), .bus_word(bus_word),
        .mode_ctl(mode_ctl), .div_ratio(div_ratio), .nib_sel(nib_sel),
        .ovl_en(ovl_en), .pix_valid(pix_valid), .pix_data(pix_data),
        .red(red), .green(green), .blue(blue), .ratio_err(ratio_err)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    int unsigned q_pix[$];
    int unsigned q_rgb[$];
    string       q_tag[$];
    bit          err_model = 0;
    string       idle_tag = "R11";

    task automatic check(input string tag, input int unsigned act, input int unsigned exp,
                         input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int unsigned ep, ergb;
        bit ev;
        string tag;
        if (q_pix.size() > 0) begin
            ev = 1; ep = q_pix.pop_front(); ergb = q_rgb.pop_front(); tag = q_tag.pop_front();
        end else begin
            ev = 0; ep = 0; ergb = 0; tag = idle_tag;
        end
        check(tag, pix_valid, ev, "pix_valid");
        check(tag, pix_data, ep, "pix_data");
        check(tag, {red, green, blue}, ergb, "rgb");
        check("R8", ratio_err, err_model, "ratio_err");
    endtask

    function automatic int mode_of(input logic [7:0] m);
        int c = int'(m[5:0]);
        return (c <= 5) ? c : 0;
    endfunction

    function automatic int nat_of(input int md);
        if (md == 0 || md == 5) return 1;
        if (md == 1) return 2;
        return 4;
    endfunction

    task automatic build(input logic [31:0] w, input logic [7:0] m, input int r,
                         input bit hi, input bit ov);
        int md = mode_of(m);
        int nat = nat_of(md);
        int n = (r == 0) ? 1 : r;
        string tag;
        q_pix.delete(); q_rgb.delete(); q_tag.delete();
        case (md)
            3: tag = "R2";
            4: tag = "R3";
            5: tag = ov ? "R4" : "R5";
            default: tag = "R1";
        endcase
        if (m[7:6] != 2'b00) tag = "R10";
        if (n != nat) tag = "R7";
        for (int k = 0; k < n; k++) begin
            int g = k % nat;
            int unsigned p = 0, rgb = 0;
            case (md)
                0: p = w & 32'hFF;
                1, 2: p = (w >> (8*g)) & 32'hFF;
                3: p = (w >> (4*g)) & 32'hF;
                4: p = (w >> (8*g + 4*int'(hi))) & 32'hF;
                default: begin
                    p = ov ? (w & 32'hFF) : 0;
                    rgb = (((w >> 8) & 32'hFF) << 16) | (((w >> 16) & 32'hFF) << 8)
                        | ((w >> 24) & 32'hFF);
                end
            endcase
            q_pix.push_back(p); q_rgb.push_back(rgb); q_tag.push_back(tag);
        end
        if (n != nat) err_model = 1;
    endtask

    task automatic cyc(input bit ld, input logic [31:0] w, input logic [7:0] m,
                       input int r, input bit hi, input bit ov);
        @(negedge clk);
        compare();
        rst = 0; load = ld; bus_word = w; mode_ctl = m;
        div_ratio = 3'(r); nib_sel = hi; ov = ov; ovl_en = ov;
        if (ld) build(w, m, r, hi, ov);
        idle_tag = "R6";
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 32'hDEAD_BEEF, 8'h02, 4, 0, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        compare();
        rst = 1; load = 0;
        q_pix.delete(); q_rgb.delete(); q_tag.delete();
        err_model = 0;
        idle_tag = "R11";
        @(negedge clk);
        compare();
        rst = 0;
    endtask

    initial begin
        rst = 1; load = 0; bus_word = 0; mode_ctl = 0; div_ratio = 1;
        nib_sel = 0; ovl_en = 1;
        @(negedge clk); @(negedge clk);
        compare();
        rst = 0;
        idle(2);
        // R1 natural counts for each bus width
        cyc(1, 32'h4433_22A1, 8'h00, 1, 0, 1); idle(2);
        cyc(1, 32'h4433_B2C1, 8'h01, 2, 0, 1); idle(3);
        cyc(1, 32'h8877_6655, 8'h02, 4, 0, 1); idle(5);
        // R2 4-bit from 16-bit bus
        cyc(1, 32'hFFFF_9A5C, 8'h03, 4, 0, 1); idle(5);
        // R3 nibble mode both halves
        cyc(1, 32'h1F2E_3D4C, 8'h04, 4, 0, 1); idle(5);
        cyc(1, 32'h1F2E_3D4C, 8'h04, 4, 1, 1); idle(5);
        // R4 / R5 true colour
        cyc(1, 32'hC0B0_A07E, 8'h05, 1, 0, 1); idle(2);
        cyc(1, 32'h1234_5678, 8'h05, 1, 0, 0); idle(2);
        // R10 upper bits ignored
        cyc(1, 32'h0A0B_0C0D, 8'hC2, 4, 0, 1); idle(5);
        cyc(1, 32'h0A0B_0C0D, 8'h45, 1, 0, 1); idle(2);
        // back-to-back loads
        cyc(1, 32'h1111_2222, 8'h01, 2, 0, 1);
        cyc(0, 0, 8'h01, 2, 0, 1);
        cyc(1, 32'h3333_4444, 8'h01, 2, 0, 1); idle(3);
        // R9 restart mid-sequence
        cyc(1, 32'hA1B2_C3D4, 8'h02, 4, 0, 1);
        idle(1);
        cyc(1, 32'h5566_7788, 8'h03, 4, 0, 1); idle(6);
        // unknown code behaves as 8-bit/8-bit
        cyc(1, 32'h0000_00E7, 8'h3F, 1, 0, 1); idle(2);
        // R7 / R8 mismatched ratios
        cyc(1, 32'h8877_6655, 8'h02, 2, 0, 1); idle(4);
        cyc(1, 32'h0000_B2C1, 8'h01, 5, 0, 1); idle(7);
        cyc(1, 32'h0000_0099, 8'h00, 0, 0, 1); idle(3);
        cyc(1, 32'hC0B0_A07E, 8'h05, 3, 0, 1); idle(2);
        // R11 reset during a sequence, flag clears
        do_reset();
        idle(3);
        cyc(1, 32'h0000_00AB, 8'h00, 7, 0, 1);
        idle(2);
        do_reset();
        idle(3);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R6 watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule